// File: doc/BRIEF.md
# Interleaved Address Restorer

This block rebuilds a system physical address from an address that a memory channel sees after interleaving has removed the channel-select bits. The caller gives the normalized address and a set of map parameters: the interleave mode, the start bit, and the channel, die and socket counts. It also gives the target's fabric ID, the map's base fabric ID and the mask/shift pairs that locate the die and socket fields inside a fabric ID. The block opens empty bit positions in the address where the interleave bits belonged. It derives the interleave ID that the target occupied and writes that ID into those positions.

Each mode fixes two things: where the gaps go and how the ID is packed. The block accepts one request per cycle over a valid/ready handshake and returns the result one cycle later through a single register stage. That stage holds its value while the consumer stalls. An unknown mode, or a mode whose parameters cannot be honoured, returns an all-ones address with the error flag set.

Top module: `intlv_addr_restore`

## Requirements
- R1: `in_ready` is high whenever the output register is empty or `out_ready` is high. A request accepted at a clock edge (`in_valid` and `in_ready` high) appears on `out_valid`/`out_addr`/`out_err` right after that edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_err` stay unchanged, `in_ready` is low, and a request offered meanwhile is taken only once the stall ends.
- R3: Mode 0 (plain): let N = ceil(log2(channels)) + log2(dies) + log2(sockets). Every address bit at or above the start bit P moves up by N, and the ID shifted left by P fills bits [P+N-1:P].
- R4: The legacy ID, used by modes 0 and 1, is built in three fields from the low end. The lowest field is (fabric − base) mod 2^ceil(log2(channels)). Next above it are the low log2(dies) bits of (fabric & die_mask) >> die_shift. At the top are the low log2(sockets) bits of (fabric & sock_mask) >> sock_shift.
- R5: Modes 1 and 2 (split): a 1-bit gap is opened at P. When N > 1, an (N−1)-bit gap is then opened at bit 12. ID bit 0 goes to bit P and ID bits [2:1] go to bits [13:12].
- R6: The modern ID, used by mode 2, starts from ((fabric & comp_mask) − (base & comp_mask)) mod 2^log2(channels). With more than one socket, that value moves up by log2(sockets) and the low socket-field bits (as in R4) fill the bottom.
- R7: Mode 3 (fixed layout) opens gaps in this order: min(log2(channels), 4) bits at bit 8, then log2(dies) bits at bit 12, then, only when log2(channels) > 4, one bit at bit 14. The swizzled ID is then ORed in at bit 8. With d = fabric − base, that ID holds d[3:0] in bits [3:0], bits [1:0] of (d & die_mask) >> die_shift in bits [5:4], and d[4] in bit 6.
- R8: In mode 3 a start bit other than 8 gives `out_err` = 1 and `out_addr` all ones.
- R9: Mode 4 (paired) uses ID = fabric − base, 16 bits wide and unmasked. It opens a 2-bit gap at bit 8, then a 2-bit gap at bit 12, and places ID[1:0] at bits [9:8] and ID[3:2] at bits [13:12].
- R10: Mode codes 5 to 15 give `out_err` = 1 and `out_addr` all ones. Modes 0 to 4 with valid parameters give `out_err` = 0.
- R11: During reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | 64 | Normalized channel address |
| in_fab_id | input | 16 | Fabric ID of the target |
| in_base_id | input | 16 | Lowest fabric ID in the map |
| in_mode | input | 4 | Interleave mode code (0 to 4 defined) |
| in_start | input | 6 | Interleave start bit P |
| in_chan_cnt | input | 6 | Number of interleaved channels (1 to 32) |
| in_die_cnt | input | 3 | Number of interleaved dies (1, 2 or 4) |
| in_sock_cnt | input | 2 | Number of interleaved sockets (1 or 2) |
| in_comp_mask | input | 16 | Component-field mask for mode 2 |
| in_die_mask | input | 16 | Die-field mask within a fabric ID |
| in_die_shift | input | 4 | Die-field right shift |
| in_sock_mask | input | 16 | Socket-field mask within a fabric ID |
| in_sock_shift | input | 4 | Socket-field right shift |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Restored system address, all ones on error |
| out_err | output | 1 | Mode or parameters invalid |

## Verification
The hardest cases to reach are those where the mode's gap layout and the width of its ID disagree. In split mode with many dies and sockets, N−1 bits open at bit 12 but only three ID bits are placed. In fixed-layout mode with 32 channels, an extra bit opens at bit 14. The stimulus sweeps every mode against every power-of-two channel count, all die counts and both socket counts. It moves the start bit and the fabric ID with each step, so these uneven layouts and field collisions all occur. The expected values come from a bit-walking gap model and modular arithmetic. A stalled-output sequence, with a second request waiting, covers the handshake.

// File: rtl/intlv_restore_pkg.sv
package intlv_restore_pkg;

    typedef enum logic [3:0] {
        MODE_PLAIN        = 4'd0,
        MODE_SPLIT_LEGACY = 4'd1,
        MODE_SPLIT_MODERN = 4'd2,
        MODE_FIXED_SWZ    = 4'd3,
        MODE_PAIRS        = 4'd4
    } mode_e;

    // Bit positions the layouts depend on
    localparam int unsigned SPLIT_HI_BIT    = 12;
    localparam int unsigned FIXED_BASE_BIT  = 8;
    localparam int unsigned FIXED_DIE_BIT   = 12;
    localparam int unsigned FIXED_EXTRA_BIT = 14;
    localparam int unsigned FIXED_CHAN_MAX  = 4;
    localparam int unsigned PAIR_LO_BIT     = 8;
    localparam int unsigned PAIR_HI_BIT     = 12;
    localparam int unsigned PAIR_WIDTH      = 2;

    function automatic int unsigned flog2(input int unsigned v);
        int unsigned r;
        r = 0;
        for (int i = 1; i < 32; i++) begin
            if ((v >> i) != 0) r = i;
        end
        return r;
    endfunction

    function automatic int unsigned clog2c(input int unsigned v);
        return (v <= 1) ? 0 : flog2(v - 1) + 1;
    endfunction

endpackage

// File: rtl/intlv_id_calc.sv
module intlv_id_calc
    import intlv_restore_pkg::*;
#(
    parameter int unsigned ID_W    = 16,
    parameter int unsigned CHAN_W  = 6,
    parameter int unsigned DIE_W   = 3,
    parameter int unsigned SOCK_W  = 2,
    parameter int unsigned SHIFT_W = 4
) (
    input  logic [3:0]         mode,
    input  logic [ID_W-1:0]    fab_id,
    input  logic [ID_W-1:0]    base_id,
    input  logic [ID_W-1:0]    comp_mask,
    input  logic [ID_W-1:0]    die_mask,
    input  logic [SHIFT_W-1:0] die_shift,
    input  logic [ID_W-1:0]    sock_mask,
    input  logic [SHIFT_W-1:0] sock_shift,
    input  logic [CHAN_W-1:0]  chan_cnt,
    input  logic [DIE_W-1:0]   die_cnt,
    input  logic [SOCK_W-1:0]  sock_cnt,
    output logic [ID_W-1:0]    id
);

    localparam logic [ID_W-1:0] ONE_ID = 1;

    function automatic logic [ID_W-1:0] low_mask(input int unsigned k);
        return (k >= ID_W) ? '1 : ((ONE_ID << k) - ONE_ID);
    endfunction

    int unsigned     lc_ceil, lc_floor, ld, ls;
    logic [ID_W-1:0] diff, die_fld, sock_fld, comp_diff, swz_die;
    logic [ID_W-1:0] id_legacy, id_modern, id_swz;

    always_comb begin
        lc_ceil   = clog2c(32'(chan_cnt));
        lc_floor  = flog2(32'(chan_cnt));
        ld        = flog2(32'(die_cnt));
        ls        = flog2(32'(sock_cnt));
        diff      = fab_id - base_id;
        die_fld   = (fab_id & die_mask) >> die_shift;
        sock_fld  = (fab_id & sock_mask) >> sock_shift;
        comp_diff = ((fab_id & comp_mask) - (base_id & comp_mask)) & low_mask(lc_floor);
        swz_die   = (diff & die_mask) >> die_shift;

        id_legacy = (diff & low_mask(lc_ceil))
                  | ((die_fld & low_mask(ld)) << lc_ceil)
                  | ((sock_fld & low_mask(ls)) << (lc_ceil + ld));

        if (sock_cnt > SOCK_W'(1))
            id_modern = (comp_diff << ls) | (sock_fld & low_mask(ls));
        else
            id_modern = comp_diff;

        id_swz = '0;
        id_swz[3:0] = diff[3:0];
        id_swz[5:4] = swz_die[1:0];
        id_swz[6]   = diff[4];

        unique case (mode)
            MODE_PLAIN,
            MODE_SPLIT_LEGACY: id = id_legacy;
            MODE_SPLIT_MODERN: id = id_modern;
            MODE_FIXED_SWZ:    id = id_swz;
            MODE_PAIRS:        id = diff;
            default:           id = '1;
        endcase
    end

endmodule

// File: rtl/intlv_gap_insert.sv
module intlv_gap_insert
    import intlv_restore_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned ID_W   = 16,
    parameter int unsigned POS_W  = 6,
    parameter int unsigned CHAN_W = 6,
    parameter int unsigned DIE_W  = 3,
    parameter int unsigned SOCK_W = 2
) (
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   id,
    input  logic [POS_W-1:0]  start,
    input  logic [CHAN_W-1:0] chan_cnt,
    input  logic [DIE_W-1:0]  die_cnt,
    input  logic [SOCK_W-1:0] sock_cnt,
    output logic [ADDR_W-1:0] addr_out,
    output logic              err
);

    localparam logic [ADDR_W-1:0] ONE_A = 1;

    // Shift every bit at or above pos up by n, leaving zeros in the hole
    function automatic logic [ADDR_W-1:0] open_gap(input logic [ADDR_W-1:0] a,
                                                   input int unsigned pos,
                                                   input int unsigned n);
        logic [ADDR_W-1:0] lo, hi;
        if (pos >= ADDR_W) return a;
        lo = a & ((ONE_A << pos) - ONE_A);
        hi = (a >> pos) << (pos + n);
        return lo | hi;
    endfunction

    int unsigned       p, n_tot, lc_ceil, lc_floor, ld, ls, chan_gap;
    logic [ADDR_W-1:0] g1, g2, g3, id_w;

    always_comb begin
        p        = 32'(start);
        lc_ceil  = clog2c(32'(chan_cnt));
        lc_floor = flog2(32'(chan_cnt));
        ld       = flog2(32'(die_cnt));
        ls       = flog2(32'(sock_cnt));
        n_tot    = lc_ceil + ld + ls;
        chan_gap = (lc_floor < FIXED_CHAN_MAX) ? lc_floor : FIXED_CHAN_MAX;
        id_w     = ADDR_W'(id);
        g1       = '0;
        g2       = '0;
        g3       = '0;
        err      = 1'b0;
        addr_out = '0;

        unique case (mode)
            MODE_PLAIN: begin
                g1       = open_gap(addr, p, n_tot);
                addr_out = g1 | (id_w << p);
            end
            MODE_SPLIT_LEGACY,
            MODE_SPLIT_MODERN: begin
                g1 = open_gap(addr, p, 1);
                g2 = (n_tot > 1) ? open_gap(g1, SPLIT_HI_BIT, n_tot - 1) : g1;
                addr_out = g2
                         | (ADDR_W'(id[0]) << p)
                         | (ADDR_W'(id[2:1]) << SPLIT_HI_BIT);
            end
            MODE_FIXED_SWZ: begin
                g1 = open_gap(addr, FIXED_BASE_BIT, chan_gap);
                g2 = open_gap(g1, FIXED_DIE_BIT, ld);
                g3 = (lc_floor > FIXED_CHAN_MAX) ? open_gap(g2, FIXED_EXTRA_BIT, 1) : g2;
                addr_out = g3 | (id_w << FIXED_BASE_BIT);
                err      = (p != FIXED_BASE_BIT);
            end
            MODE_PAIRS: begin
                g1 = open_gap(addr, PAIR_LO_BIT, PAIR_WIDTH);
                g2 = open_gap(g1, PAIR_HI_BIT, PAIR_WIDTH);
                addr_out = g2
                         | (ADDR_W'(id[1:0]) << PAIR_LO_BIT)
                         | (ADDR_W'(id[3:2]) << PAIR_HI_BIT);
            end
            default: err = 1'b1;
        endcase

        if (err) addr_out = '1;
    end

endmodule

// File: rtl/intlv_addr_restore.sv
module intlv_addr_restore
    import intlv_restore_pkg::*;
#(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned ID_W    = 16,
    parameter int unsigned POS_W   = 6,
    parameter int unsigned CHAN_W  = 6,
    parameter int unsigned DIE_W   = 3,
    parameter int unsigned SOCK_W  = 2,
    parameter int unsigned SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [ID_W-1:0]    in_fab_id,
    input  logic [ID_W-1:0]    in_base_id,
    input  logic [3:0]         in_mode,
    input  logic [POS_W-1:0]   in_start,
    input  logic [CHAN_W-1:0]  in_chan_cnt,
    input  logic [DIE_W-1:0]   in_die_cnt,
    input  logic [SOCK_W-1:0]  in_sock_cnt,
    input  logic [ID_W-1:0]    in_comp_mask,
    input  logic [ID_W-1:0]    in_die_mask,
    input  logic [SHIFT_W-1:0] in_die_shift,
    input  logic [ID_W-1:0]    in_sock_mask,
    input  logic [SHIFT_W-1:0] in_sock_shift,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_err
);

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } stage_t;

    stage_t            st_d, st_q;
    logic [ID_W-1:0]   id_w;
    logic [ADDR_W-1:0] comb_addr;
    logic              comb_err;

    intlv_id_calc #(
        .ID_W(ID_W), .CHAN_W(CHAN_W), .DIE_W(DIE_W),
        .SOCK_W(SOCK_W), .SHIFT_W(SHIFT_W)
    ) u_id (
        .mode      (in_mode),
        .fab_id    (in_fab_id),
        .base_id   (in_base_id),
        .comp_mask (in_comp_mask),
        .die_mask  (in_die_mask),
        .die_shift (in_die_shift),
        .sock_mask (in_sock_mask),
        .sock_shift(in_sock_shift),
        .chan_cnt  (in_chan_cnt),
        .die_cnt   (in_die_cnt),
        .sock_cnt  (in_sock_cnt),
        .id        (id_w)
    );

    intlv_gap_insert #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .POS_W(POS_W),
        .CHAN_W(CHAN_W), .DIE_W(DIE_W), .SOCK_W(SOCK_W)
    ) u_gap (
        .mode    (in_mode),
        .addr    (in_addr),
        .id      (id_w),
        .start   (in_start),
        .chan_cnt(in_chan_cnt),
        .die_cnt (in_die_cnt),
        .sock_cnt(in_sock_cnt),
        .addr_out(comb_addr),
        .err     (comb_err)
    );

    assign in_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_valid && in_ready) begin
            st_d.vld  = 1'b1;
            st_d.err  = comb_err;
            st_d.addr = comb_addr;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_addr  = st_q.addr;
    assign out_err   = st_q.err;

endmodule

// File: rtl/intlv_restore_chk.sv
module intlv_restore_chk #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned POS_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [3:0]        in_mode,
    input logic [POS_W-1:0]  in_start,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_err
);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_empty_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_err));

    p_bad_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode == 4'd3 && in_start != POS_W'(8) |=> out_err);

    p_unknown_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_mode > 4'd4 |=> out_valid && out_err);

    p_err_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_addr == '1);

endmodule

bind intlv_addr_restore intlv_restore_chk #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_mode  (in_mode),
    .in_start (in_start),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_addr (out_addr),
    .out_err  (out_err)
);

// File: tb/intlv_addr_restore_bench.sv
`timescale 1ns/1ps
module intlv_addr_restore_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_addr = '0;
    logic [15:0] in_fab_id = '0, in_base_id = '0;
    logic [3:0]  in_mode = '0;
    logic [5:0]  in_start = 6'd8;
    logic [5:0]  in_chan_cnt = 6'd1;
    logic [2:0]  in_die_cnt = 3'd1;
    logic [1:0]  in_sock_cnt = 2'd1;
    logic [15:0] in_comp_mask = 16'h00FF;
    logic [15:0] in_die_mask = 16'h0030;
    logic [3:0]  in_die_shift = 4'd4;
    logic [15:0] in_sock_mask = 16'h0100;
    logic [3:0]  in_sock_shift = 4'd8;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_addr;
    logic        out_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    intlv_addr_restore u_intlv_addr_restore (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] m_gap(input logic [63:0] a, input int p, input int n);
        logic [63:0] r;
        int s;
        r = '0;
        s = 0;
        for (int i = 0; i < 64; i++) begin
            if (i >= p && i < p + n) r[i] = 1'b0;
            else begin r[i] = a[s]; s++; end
        end
        return r;
    endfunction

    function automatic int lg(input int v);
        int r;
        r = 0;
        while ((1 << (r + 1)) <= v) r++;
        return r;
    endfunction

    function automatic int lgc(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    function automatic logic [63:0] expect_addr(input int mode, input logic [63:0] a,
            input int fab, input int base, input int p, input int ch, input int di, input int so);
        int diff, cc, lc, ld, ls, n, id, dfld, sfld, cpart;
        logic [63:0] g;
        diff = (fab - base) & 16'hFFFF;
        cc = lgc(ch); lc = lg(ch); ld = lg(di); ls = lg(so);
        n = cc + ld + ls;
        dfld = (fab & 16'h0030) >> 4;
        sfld = (fab & 16'h0100) >> 8;
        case (mode)
            0, 1: id = (diff % (1 << cc)) + (dfld % di) * (1 << cc) + (sfld % so) * (1 << (cc + ld));
            2: begin
                cpart = (((fab & 16'h00FF) - (base & 16'h00FF)) & 16'hFFFF) % (1 << lc);
                id = (so > 1) ? cpart * so + (sfld % so) : cpart;
            end
            3: id = ((diff >> 4) & 1) * 64 + (((diff & 16'h0030) >> 4) & 3) * 16 + (diff & 15);
            default: id = diff;
        endcase
        case (mode)
            0: return m_gap(a, p, n) | (64'(id) << p);
            1, 2: begin
                g = m_gap(a, p, 1);
                if (n > 1) g = m_gap(g, 12, n - 1);
                return g | (64'(id & 1) << p) | (64'((id >> 1) & 3) << 12);
            end
            3: begin
                g = m_gap(a, 8, (lc < 4) ? lc : 4);
                g = m_gap(g, 12, ld);
                if (lc > 4) g = m_gap(g, 14, 1);
                return g | (64'(id) << 8);
            end
            default: begin
                g = m_gap(a, 8, 2);
                g = m_gap(g, 12, 2);
                return g | (64'(id & 3) << 8) | (64'((id >> 2) & 3) << 12);
            end
        endcase
    endfunction

    task automatic send(input int mode, input logic [63:0] a, input int fab, input int base,
                        input int p, input int ch, input int di, input int so);
        @(negedge clk);
        in_valid = 1'b1; in_mode = 4'(mode); in_addr = a;
        in_fab_id = 16'(fab); in_base_id = 16'(base); in_start = 6'(p);
        in_chan_cnt = 6'(ch); in_die_cnt = 3'(di); in_sock_cnt = 2'(so);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string mtag(input int mode);
        case (mode)
            0: return "R3/R4";
            1: return "R5/R4";
            2: return "R5/R6";
            3: return "R7";
            default: return "R9";
        endcase
    endfunction

    initial begin
        logic [63:0] a, held;
        int fab, base, p, k;
        k = 0;
        #1;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 out_valid", 64'(out_valid), 64'd0);
        check("R11 in_ready", 64'(in_ready), 64'd1);
        @(negedge clk) rst_n = 1'b1;

        for (int mode = 0; mode < 5; mode++)
            for (int ci = 0; ci < 6; ci++)
                for (int di = 0; di < 3; di++)
                    for (int si = 0; si < 2; si++)
                        for (int t = 0; t < 2; t++) begin
                            k++;
                            a    = 64'h9E37_79B9_7F4A_7C15 * 64'(k);
                            fab  = (t * 16'h0137 + ci * 16'h0053 + di * 16'h0091 + si * 16'h0101 + mode * 7 + 16'h0020) & 16'hFFFF;
                            base = 4 + t;
                            p    = (mode == 3) ? 8 : 8 + ((ci + di + t) % 4);
                            send(mode, a, fab, base, p, 1 << ci, 1 << di, 1 << si);
                            check("R1 out_valid", 64'(out_valid), 64'd1);
                            check({mtag(mode), " addr"}, out_addr,
                                  expect_addr(mode, a, fab, base, p, 1 << ci, 1 << di, 1 << si));
                            check("R10 err clear", 64'(out_err), 64'd0);
                        end

        // R8: fixed layout with a start bit other than 8
        send(3, 64'h1234_5678_9ABC_DEF0, 16'h0025, 4, 9, 8, 2, 1);
        check("R8 err", 64'(out_err), 64'd1);
        check("R8 ones", out_addr, '1);

        // R10: unknown mode codes
        send(5, 64'h0F0F_0F0F_0F0F_0F0F, 16'h0011, 1, 8, 4, 1, 1);
        check("R10 err mode5", 64'(out_err), 64'd1);
        check("R10 ones mode5", out_addr, '1);
        send(15, 64'h0, 16'h0011, 1, 8, 4, 1, 1);
        check("R10 err mode15", 64'(out_err), 64'd1);
        check("R10 ones mode15", out_addr, '1);

        // R2: stall with a second request waiting
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_mode = 4'd4; in_addr = 64'hFFFF_0000_FFFF_0000;
        in_fab_id = 16'h000B; in_base_id = 16'h0001;
        @(negedge clk);
        held = out_addr;
        check("R2 accepted", 64'(out_valid), 64'd1);
        check("R2 first result", held, expect_addr(4, 64'hFFFF_0000_FFFF_0000, 16'h000B, 1, 8, 4, 1, 1));
        in_addr = 64'h0000_0000_0000_00FF; in_fab_id = 16'h0007;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R2 valid held", 64'(out_valid), 64'd1);
            check("R2 addr held", out_addr, held);
            check("R2 in_ready low", 64'(in_ready), 64'd0);
        end
        out_ready = 1'b1;
        #1 check("R1 ready on out_ready", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 second taken", out_addr, expect_addr(4, 64'h0000_0000_0000_00FF, 16'h0007, 1, 8, 4, 1, 1));
        @(negedge clk);
        check("R1 drained", 64'(out_valid), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule